// File: doc/BRIEF.md
# Hardware Return Address Stack

This block keeps the return addresses of a small processor core in a dedicated on-chip stack. It has 31 entries of 21 bits each and a 5-bit pointer. Location zero holds no entry and means the stack is empty. A call pushes a return address. A return pops the entry at the pointer back to the core. Software can push the current program counter, discard the top entry, and rewrite the top entry one byte slice at a time.

A combined status/pointer register shows two sticky flags, one for full and one for underflow, together with the pointer. Software can write the pointer field. Software can only clear the two flags. An input selects what happens when a push fills the stack:

- In reset mode, the block raises a one-cycle device-reset request and returns the pointer to zero.
- In hold mode, the pointer saturates at the last entry, and any further push is ignored.

A pop on an empty stack returns address zero and sets the underflow flag. The core then vectors to address zero.

Top module: `ret_addr_stack`

## Requirements
- R1: After power-on reset the pointer, both flags, `tos_q`, `pop_addr` and `rst_req` are all zero.
- R2: A push (`call_push` or `sw_push`) first increments the pointer and then stores `push_val` at the new pointer. `tos_q` then shows that value.
- R3: A return (`ret_pop`) loads `pop_addr` with the entry at the current pointer and then decrements the pointer. `pop_addr` changes only on a return.
- R4: A return or discard while the pointer is zero sets the underflow flag and leaves the pointer at zero. For a return, `pop_addr` becomes zero.
- R5: A discard (`sw_drop`) at a nonzero pointer decrements the pointer and leaves `pop_addr` unchanged.
- R6: In reset mode (`cfg_ovf_reset`=1), a push that brings the pointer to 31 still stores its value and sets the full flag. The pointer becomes zero, and `rst_req` is high for exactly the following cycle. A push while the pointer is already 31 stores nothing and has the same effect on the flag, the pointer and `rst_req`.
- R7: In hold mode (`cfg_ovf_reset`=0), a push that brings the pointer to 31 sets the full flag. A push while the pointer is 31 sets the full flag, keeps the pointer at 31 and leaves entry 31 unchanged.
- R8: `stat_q` has the full flag in bit 7, the underflow flag in bit 6, zero in bit 5 and the pointer in bits 4:0. A status write loads bits 4:0 into the pointer.
- R9: A status write clears each flag whose bit (7 or 6) is written 0. A 1 in those bits leaves the flag as it was. No other event clears a flag.
- R10: A status write in the same cycle as a push or pop takes priority. The push or pop is dropped entirely, and the pointer takes the written value.
- R11: `tos_we` bit 0 writes `tos_wdata` into bits 7:0 of the entry at the current pointer. Bit 1 writes bits 15:8. Bit 2 writes bits 20:16 from `tos_wdata[4:0]`. These writes have no effect while the pointer is zero, and `tos_q` reads zero there.
- R12: When a push and a pop (or discard) come in the same cycle, the push is performed and the pop is dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low power-on reset, asynchronous |
| cfg_ovf_reset | input | 1 | 1 = reset request on overflow, 0 = saturate and hold |
| call_push | input | 1 | Push `push_val` as a call return address |
| sw_push | input | 1 | Software push of the current program counter in `push_val` |
| push_val | input | 21 | Address to push |
| ret_pop | input | 1 | Return: pop the top entry into `pop_addr` |
| sw_drop | input | 1 | Discard the top entry |
| tos_we | input | 3 | Top-of-stack byte slice write enables (upper, high, low) |
| tos_wdata | input | 8 | Top-of-stack slice write data |
| stat_wr | input | 1 | Status/pointer register write strobe |
| stat_wdata | input | 8 | Status/pointer register write data |
| tos_q | output | 21 | Entry at the current pointer (zero when the pointer is zero) |
| pop_addr | output | 21 | Address returned by the last return |
| stat_q | output | 8 | Status/pointer register |
| rst_req | output | 1 | One-cycle device-reset request on overflow |

## Verification
Every state change takes effect at the clock edge on which the command is sampled. `tos_q` and `stat_q` are read straight from state, so they show the new value in the cycle that follows that edge. `pop_addr` and `rst_req` are registers loaded at that same edge, so they are also due one cycle after the command, and `rst_req` falls again one edge later. The bench drives each command on a falling edge and lets one rising edge pass. At the next falling edge it compares all four outputs with a bench model that it steps once per command. The following idle cycle then confirms that the reset pulse has ended.

// File: rtl/rstk_pkg.sv
package rstk_pkg;

   // Operation granted to the stack in one cycle after priority resolution
   typedef enum logic [1:0] {
      STK_IDLE = 2'd0,
      STK_PUSH = 2'd1,
      STK_RET  = 2'd2,
      STK_DROP = 2'd3
   } stk_op_e;

   // Fixed bit positions inside the status/pointer register
   localparam int STAT_W       = 8;
   localparam int STAT_FULL_B  = 7;
   localparam int STAT_UNF_B   = 6;
   localparam int STAT_PTR_MAX = 5;

   // Byte-slice enable positions for top-of-stack writes
   localparam int TOS_LO_B = 0;
   localparam int TOS_HI_B = 1;
   localparam int TOS_UP_B = 2;

endpackage

// File: rtl/rstk_cmd_arb.sv
module rstk_cmd_arb
   import rstk_pkg::*;
(
   input  logic    call_push,
   input  logic    sw_push,
   input  logic    ret_pop,
   input  logic    sw_drop,
   input  logic    stat_wr,
   output stk_op_e op
);

   // Status write beats everything, push beats pop, return beats discard
   always_comb begin
      if (stat_wr) begin
         op = STK_IDLE;
      end else if (call_push || sw_push) begin
         op = STK_PUSH;
      end else if (ret_pop) begin
         op = STK_RET;
      end else if (sw_drop) begin
         op = STK_DROP;
      end else begin
         op = STK_IDLE;
      end
   end

endmodule

// File: rtl/rstk_ptr_ctrl.sv
module rstk_ptr_ctrl
   import rstk_pkg::*;
#(
   parameter int PTR_W = 5
) (
   input  logic               clk,
   input  logic               rst_n,
   input  stk_op_e            op,
   input  logic               ovf_rst_en,
   input  logic               stat_wr,
   input  logic [STAT_W-1:0]  stat_wdata,
   output logic [PTR_W-1:0]   ptr_q,
   output logic               full_q,
   output logic               unf_q,
   output logic               push_we,
   output logic [PTR_W-1:0]   push_idx,
   output logic               rst_req_q
);

   localparam logic [PTR_W-1:0] PTR_TOP  = {PTR_W{1'b1}};
   localparam logic [PTR_W-1:0] PTR_ZERO = '0;
   localparam logic [PTR_W-1:0] PTR_ONE  = PTR_W'(1);

   logic [PTR_W-1:0] ptr_d;
   logic             full_d;
   logic             unf_d;
   logic             rst_req_d;
   logic [PTR_W-1:0] ptr_inc;
   logic             at_top;
   logic             at_base;
   logic             unused_wdata;

   assign ptr_inc      = ptr_q + PTR_ONE;
   assign at_top       = (ptr_q == PTR_TOP);
   assign at_base      = (ptr_q == PTR_ZERO);
   assign push_idx     = ptr_inc;
   assign unused_wdata = ^stat_wdata;

   always_comb begin
      ptr_d     = ptr_q;
      full_d    = full_q;
      unf_d     = unf_q;
      rst_req_d = 1'b0;
      push_we   = 1'b0;
      if (stat_wr) begin
         ptr_d  = stat_wdata[PTR_W-1:0];
         full_d = full_q & stat_wdata[STAT_FULL_B];
         unf_d  = unf_q  & stat_wdata[STAT_UNF_B];
      end else begin
         unique case (op)
            STK_PUSH: begin
               if (at_top) begin
                  full_d = 1'b1;
                  if (ovf_rst_en) begin
                     ptr_d     = PTR_ZERO;
                     rst_req_d = 1'b1;
                  end
               end else begin
                  push_we = 1'b1;
                  ptr_d   = ptr_inc;
                  if (ptr_inc == PTR_TOP) begin
                     full_d = 1'b1;
                     if (ovf_rst_en) begin
                        ptr_d     = PTR_ZERO;
                        rst_req_d = 1'b1;
                     end
                  end
               end
            end
            STK_RET, STK_DROP: begin
               if (at_base) begin
                  unf_d = 1'b1;
               end else begin
                  ptr_d = ptr_q - PTR_ONE;
               end
            end
            default: begin
               ptr_d = ptr_q;
            end
         endcase
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ptr_q     <= PTR_ZERO;
         full_q    <= 1'b0;
         unf_q     <= 1'b0;
         rst_req_q <= 1'b0;
      end else begin
         ptr_q     <= ptr_d;
         full_q    <= full_d;
         unf_q     <= unf_d;
         rst_req_q <= rst_req_d;
      end
   end

endmodule

// File: rtl/rstk_storage.sv
module rstk_storage
   import rstk_pkg::*;
#(
   parameter int ADDR_W = 21,
   parameter int PTR_W  = 5
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              push_we,
   input  logic [PTR_W-1:0]  push_idx,
   input  logic [ADDR_W-1:0] push_data,
   input  logic [2:0]        tosw_we,
   input  logic [PTR_W-1:0]  tosw_idx,
   input  logic [7:0]        tosw_data,
   input  logic [PTR_W-1:0]  rd_idx,
   output logic [ADDR_W-1:0] rd_data
);

   localparam int DEPTH = (1 << PTR_W) - 1;
   localparam int UP_W  = ADDR_W - 16;

   // Slot 0 is a constant zero so an empty stack reads back zero
   logic [(DEPTH+1)*ADDR_W-1:0] flat;
   logic                        unused_tosw;

   assign flat[ADDR_W-1:0] = '0;
   assign unused_tosw      = ^tosw_data;

   for (genvar e = 1; e <= DEPTH; e++) begin : g_ent
      localparam logic [PTR_W-1:0] IDX = PTR_W'(e);
      logic [ADDR_W-1:0] ent_q;
      logic              hit_push;
      logic              hit_tos;

      assign hit_push = push_we && (push_idx == IDX);
      assign hit_tos  = (tosw_idx == IDX);

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            ent_q <= '0;
         end else if (hit_push) begin
            ent_q <= push_data;
         end else if (hit_tos) begin
            if (tosw_we[TOS_LO_B]) ent_q[7:0]        <= tosw_data;
            if (tosw_we[TOS_HI_B]) ent_q[15:8]       <= tosw_data;
            if (tosw_we[TOS_UP_B]) ent_q[ADDR_W-1:16] <= tosw_data[UP_W-1:0];
         end
      end

      assign flat[e*ADDR_W +: ADDR_W] = ent_q;
   end

   assign rd_data = flat[int'(rd_idx)*ADDR_W +: ADDR_W];

endmodule

// File: rtl/ret_addr_stack.sv
module ret_addr_stack
   import rstk_pkg::*;
#(
   parameter int ADDR_W = 21,
   parameter int PTR_W  = 5
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cfg_ovf_reset,
   input  logic              call_push,
   input  logic              sw_push,
   input  logic [ADDR_W-1:0] push_val,
   input  logic              ret_pop,
   input  logic              sw_drop,
   input  logic [2:0]        tos_we,
   input  logic [7:0]        tos_wdata,
   input  logic              stat_wr,
   input  logic [7:0]        stat_wdata,
   output logic [ADDR_W-1:0] tos_q,
   output logic [ADDR_W-1:0] pop_addr,
   output logic [7:0]        stat_q,
   output logic              rst_req
);

   // Elaboration-time parameter checks
   if (ADDR_W < 17 || ADDR_W > 24) begin : g_bad_addr_w
      $error("ret_addr_stack: ADDR_W must lie in 17..24 for three byte slices");
   end
   if (PTR_W < 2 || PTR_W > STAT_PTR_MAX) begin : g_bad_ptr_w
      $error("ret_addr_stack: PTR_W must lie in 2..5 to fit the status register");
   end

   stk_op_e           op;
   logic [PTR_W-1:0]  ptr;
   logic              full_flag;
   logic              unf_flag;
   logic              push_we;
   logic [PTR_W-1:0]  push_idx;
   logic [ADDR_W-1:0] pop_q;

   rstk_cmd_arb u_arb (
      .call_push (call_push),
      .sw_push   (sw_push),
      .ret_pop   (ret_pop),
      .sw_drop   (sw_drop),
      .stat_wr   (stat_wr),
      .op        (op)
   );

   rstk_ptr_ctrl #(.PTR_W(PTR_W)) u_ctrl (
      .clk        (clk),
      .rst_n      (rst_n),
      .op         (op),
      .ovf_rst_en (cfg_ovf_reset),
      .stat_wr    (stat_wr),
      .stat_wdata (stat_wdata),
      .ptr_q      (ptr),
      .full_q     (full_flag),
      .unf_q      (unf_flag),
      .push_we    (push_we),
      .push_idx   (push_idx),
      .rst_req_q  (rst_req)
   );

   rstk_storage #(.ADDR_W(ADDR_W), .PTR_W(PTR_W)) u_mem (
      .clk       (clk),
      .rst_n     (rst_n),
      .push_we   (push_we),
      .push_idx  (push_idx),
      .push_data (push_val),
      .tosw_we   (tos_we),
      .tosw_idx  (ptr),
      .tosw_data (tos_wdata),
      .rd_idx    (ptr),
      .rd_data   (tos_q)
   );

   // Return value register: entry at the pointer, zero on an empty stack
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pop_q <= '0;
      end else if (op == STK_RET) begin
         pop_q <= tos_q;
      end
   end

   assign pop_addr = pop_q;

   always_comb begin
      stat_q                       = '0;
      stat_q[STAT_FULL_B]          = full_flag;
      stat_q[STAT_UNF_B]           = unf_flag;
      stat_q[PTR_W-1:0]            = ptr;
   end

endmodule

// File: rtl/rstk_checker.sv
module rstk_checker #(
   parameter int ADDR_W = 21,
   parameter int PTR_W  = 5
) (
   input logic              clk,
   input logic              rst_n,
   input logic              cfg_ovf_reset,
   input logic              call_push,
   input logic              sw_push,
   input logic [ADDR_W-1:0] push_val,
   input logic              ret_pop,
   input logic              sw_drop,
   input logic [2:0]        tos_we,
   input logic              stat_wr,
   input logic [7:0]        stat_wdata,
   input logic [ADDR_W-1:0] tos_q,
   input logic [ADDR_W-1:0] pop_addr,
   input logic [7:0]        stat_q,
   input logic              rst_req
);

   localparam logic [PTR_W-1:0] TOP = {PTR_W{1'b1}};

   logic [PTR_W-1:0] ptr;
   logic             push;
   assign ptr  = stat_q[PTR_W-1:0];
   assign push = call_push | sw_push;

   assert_push_grows_R2: assert property (@(posedge clk) disable iff (!rst_n)
      push && !stat_wr && ptr < TOP - 1 |=> ptr == $past(ptr) + 1'b1 && tos_q == $past(push_val));

   assert_ret_value_R3: assert property (@(posedge clk) disable iff (!rst_n)
      ret_pop && !push && !stat_wr && ptr != '0 |=> pop_addr == $past(tos_q));

   assert_underflow_R4: assert property (@(posedge clk) disable iff (!rst_n)
      ret_pop && !push && !stat_wr && ptr == '0 |=> stat_q[6] && pop_addr == '0 && ptr == '0);

   assert_drop_keeps_R5: assert property (@(posedge clk) disable iff (!rst_n)
      sw_drop && !ret_pop && !push && !stat_wr && ptr != '0 |=> $stable(pop_addr) && ptr == $past(ptr) - 1'b1);

   assert_rst_pulse_R6: assert property (@(posedge clk) disable iff (!rst_n)
      rst_req |=> !rst_req);

   assert_rst_state_R6: assert property (@(posedge clk) disable iff (!rst_n)
      rst_req |-> stat_q[7] && ptr == '0);

   assert_hold_saturates_R7: assert property (@(posedge clk) disable iff (!rst_n)
      !cfg_ovf_reset && push && !stat_wr && tos_we == 3'b000 && ptr == TOP |=> ptr == TOP && $stable(tos_q) && stat_q[7]);

   assert_spare_bit_R8: assert property (@(posedge clk) disable iff (!rst_n)
      stat_q[5] == 1'b0);

   assert_full_sticky_R9: assert property (@(posedge clk) disable iff (!rst_n)
      stat_q[7] && !stat_wr |=> stat_q[7]);

   assert_unf_sticky_R9: assert property (@(posedge clk) disable iff (!rst_n)
      stat_q[6] && !stat_wr |=> stat_q[6]);

   assert_stat_wins_R10: assert property (@(posedge clk) disable iff (!rst_n)
      stat_wr |=> ptr == $past(stat_wdata[PTR_W-1:0]));

   assert_base_reads_zero_R11: assert property (@(posedge clk) disable iff (!rst_n)
      ptr == '0 |-> tos_q == '0);

   assert_push_over_pop_R12: assert property (@(posedge clk) disable iff (!rst_n)
      push && (ret_pop || sw_drop) && !stat_wr && ptr < TOP - 1 |=> ptr == $past(ptr) + 1'b1);

endmodule

bind ret_addr_stack rstk_checker #(.ADDR_W(ADDR_W), .PTR_W(PTR_W)) u_rstk_chk (
   .clk           (clk),
   .rst_n         (rst_n),
   .cfg_ovf_reset (cfg_ovf_reset),
   .call_push     (call_push),
   .sw_push       (sw_push),
   .push_val      (push_val),
   .ret_pop       (ret_pop),
   .sw_drop       (sw_drop),
   .tos_we        (tos_we),
   .stat_wr       (stat_wr),
   .stat_wdata    (stat_wdata),
   .tos_q         (tos_q),
   .pop_addr      (pop_addr),
   .stat_q        (stat_q),
   .rst_req       (rst_req)
);

// File: tb/tb_ret_addr_stack.sv
module tb_ret_addr_stack;

   localparam int CLK_PERIOD = 10;
   localparam int AW = 21;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          cfg_ovf_reset = 1'b1;
   logic          call_push = 1'b0, sw_push = 1'b0, ret_pop = 1'b0, sw_drop = 1'b0;
   logic [AW-1:0] push_val = '0;
   logic [2:0]    tos_we = '0;
   logic [7:0]    tos_wdata = '0;
   logic          stat_wr = 1'b0;
   logic [7:0]    stat_wdata = '0;
   logic [AW-1:0] tos_q, pop_addr;
   logic [7:0]    stat_q;
   logic          rst_req;

   always #(CLK_PERIOD/2) clk = ~clk;

   ret_addr_stack dut (
      .clk(clk), .rst_n(rst_n), .cfg_ovf_reset(cfg_ovf_reset),
      .call_push(call_push), .sw_push(sw_push), .push_val(push_val),
      .ret_pop(ret_pop), .sw_drop(sw_drop), .tos_we(tos_we), .tos_wdata(tos_wdata),
      .stat_wr(stat_wr), .stat_wdata(stat_wdata),
      .tos_q(tos_q), .pop_addr(pop_addr), .stat_q(stat_q), .rst_req(rst_req)
   );

   int n_vec = 0;
   int n_bad = 0;
   bit done = 1'b0;

   // Bench model
   logic [AW-1:0] m_mem [0:31];
   int            m_ptr;
   bit            m_full, m_unf, m_rst;
   logic [AW-1:0] m_pop;

   function automatic logic [AW-1:0] m_tos();
      return (m_ptr == 0) ? '0 : m_mem[m_ptr];
   endfunction

   function automatic void model_step();
      bit push = call_push | sw_push;
      bit pop  = ret_pop | sw_drop;
      m_rst = 1'b0;
      if (m_ptr != 0) begin
         if (tos_we[0]) m_mem[m_ptr][7:0]   = tos_wdata;
         if (tos_we[1]) m_mem[m_ptr][15:8]  = tos_wdata;
         if (tos_we[2]) m_mem[m_ptr][20:16] = tos_wdata[4:0];
      end
      if (stat_wr) begin
         m_ptr  = int'(stat_wdata[4:0]);
         m_full = m_full & stat_wdata[7];
         m_unf  = m_unf & stat_wdata[6];
      end else if (push) begin
         if (m_ptr == 31) begin
            m_full = 1'b1;
            if (cfg_ovf_reset) begin m_ptr = 0; m_rst = 1'b1; end
         end else begin
            m_ptr = m_ptr + 1;
            m_mem[m_ptr] = push_val;
            if (m_ptr == 31) begin
               m_full = 1'b1;
               if (cfg_ovf_reset) begin m_ptr = 0; m_rst = 1'b1; end
            end
         end
      end else if (pop) begin
         if (m_ptr == 0) begin
            m_unf = 1'b1;
            if (ret_pop) m_pop = '0;
         end else begin
            if (ret_pop) m_pop = m_mem[m_ptr];
            m_ptr = m_ptr - 1;
         end
      end
   endfunction

   task automatic chk(string req, string what, logic [31:0] act, logic [31:0] exp);
      n_vec++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s %s: actual %0h expected %0h at %0t", req, what, act, exp, $time);
      end
   endtask

   task automatic check_all(string req);
      chk(req, "tos_q", 32'(tos_q), 32'(m_tos()));
      chk(req, "stat_q", 32'(stat_q), {24'd0, m_full, m_unf, 1'b0, 5'(m_ptr)});
      chk(req, "pop_addr", 32'(pop_addr), 32'(m_pop));
      chk(req, "rst_req", 32'(rst_req), 32'(m_rst));
   endtask

   task automatic idle_inputs();
      call_push = 0; sw_push = 0; ret_pop = 0; sw_drop = 0;
      tos_we = '0; stat_wr = 0;
   endtask

   // Inputs are already driven (we are just past a falling edge)
   task automatic step(string req);
      model_step();
      @(posedge clk);
      @(negedge clk);
      idle_inputs();
      check_all(req);
   endtask

   task automatic do_push(string req, logic [AW-1:0] v, bit by_sw);
      push_val = v; if (by_sw) sw_push = 1; else call_push = 1;
      step(req);
   endtask

   task automatic do_stat(string req, logic [7:0] w);
      stat_wr = 1; stat_wdata = w;
      step(req);
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         n_bad++;
         $display("FAIL watchdog: run did not finish, actual hung expected done");
         $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
         $finish;
      end
   end

   initial begin
      for (int i = 0; i < 32; i++) m_mem[i] = '0;
      m_ptr = 0; m_full = 0; m_unf = 0; m_rst = 0; m_pop = '0;
      void'($urandom(32'd20240611));
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      check_all("R1");

      // Pushes and TOS slice writes
      do_push("R2", 21'h12345, 0);
      do_push("R2", 21'h0ABCD, 1);
      do_push("R2", 21'h1FFFF, 0);
      tos_we = 3'b001; tos_wdata = 8'h5A; step("R11");
      tos_we = 3'b110; tos_wdata = 8'hE3; step("R11");
      // Returns and discards
      ret_pop = 1; step("R3");
      sw_drop = 1; step("R5");
      ret_pop = 1; step("R3");
      ret_pop = 1; step("R4");
      sw_drop = 1; step("R4");
      tos_we = 3'b111; tos_wdata = 8'hFF; step("R11");
      // Clear-only flags
      do_stat("R9", 8'hC0);
      do_stat("R9", 8'h80);
      do_stat("R8", 8'h03);
      // Status write beats push
      stat_wr = 1; stat_wdata = 8'h01; call_push = 1; push_val = 21'h777; step("R10");
      // Push beats pop
      push_val = 21'h0BEEF; sw_push = 1; ret_pop = 1; step("R12");

      // Hold mode: fill to 31 then overflow
      cfg_ovf_reset = 0;
      do_stat("R7", 8'h00);
      for (int i = 1; i <= 31; i++) do_push("R7", AW'(i * 7 + 3), i[0]);
      do_push("R7", 21'h1DEAD, 0);
      do_push("R7", 21'h0F00D, 1);
      ret_pop = 1; step("R7");

      // Reset mode: fill to 31, expect pulse then drop
      cfg_ovf_reset = 1;
      do_stat("R6", 8'h00);
      for (int i = 1; i <= 31; i++) do_push("R6", AW'(i * 11 + 1), 0);
      step("R6");
      do_stat("R6", 8'h1F);
      do_push("R6", 21'h00042, 1);
      step("R6");

      // Constrained random traffic
      for (int n = 0; n < 4000; n++) begin
         int r;
         string tg;
         if (n % 700 == 0) cfg_ovf_reset = $urandom % 2;
         r = $urandom % 16;
         push_val = AW'($urandom);
         if (r < 6) begin
            if (r[0]) sw_push = 1; else call_push = 1;
            tg = (m_ptr >= 30) ? (cfg_ovf_reset ? "R6" : "R7") : "R2";
         end else if (r < 10) begin
            ret_pop = 1; tg = (m_ptr == 0) ? "R4" : "R3";
         end else if (r < 12) begin
            sw_drop = 1; tg = (m_ptr == 0) ? "R4" : "R5";
         end else if (r == 12) begin
            tos_we = 3'($urandom); tos_wdata = 8'($urandom); tg = "R11";
         end else if (r == 13) begin
            stat_wr = 1; stat_wdata = 8'($urandom);
            if ($urandom % 2 == 1) call_push = 1;
            if ($urandom % 2 == 1) ret_pop = 1;
            tg = "R10";
         end else if (r == 14) begin
            call_push = 1; sw_drop = 1; tg = "R12";
         end else begin
            tg = "R8";
         end
         step(tg);
      end

      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
   end

endmodule